// File: doc/BRIEF.md
# Variable-Page Address Translation Checker

This block turns a 32-bit virtual address into a physical address, or into a 12-bit exception code when the access may not proceed. It holds a small, fully associative translation table. Each entry carries its own page size (1 KB, 4 KB, 64 KB or 1 MB), an address-space tag, a shared flag, two protection bits and a dirty bit. Entries are loaded one whole entry at a time through a write port.

Each accepted request carries an address, an access kind and a privilege flag. The block first looks at the address region. Two fixed regions bypass the table: one folds its address down to 29 bits and the other passes it through unchanged. When translation is disabled, every other address is folded to 29 bits. In all remaining cases the table is searched. The search detects a miss or more than one hit, then checks the protection bits against the access kind and privilege. The result is registered and returned one cycle after the request is accepted. On a fault, the block latches the faulting address for the exception handler, and it latches the page number for a refill routine.

Top module: `vpt_xlate`

## Requirements
- R1: After reset, rsp_valid, tea and pteh_vpn are 0 and every table entry is invalid, so a lookup needing the table misses.
- R2: req_ready is low in any cycle where wr_en is high. A request is accepted when req_valid and req_ready are both high, and it produces exactly one rsp_valid pulse in the next cycle. Cycles with no accepted request produce no rsp_valid pulse.
- R3: For a privileged access, an address in 0x80000000..0xBFFFFFFF succeeds with paddr = vaddr & 0x1FFFFFFF. An address at or above 0xE0000000 succeeds with paddr = vaddr. Neither result depends on xlate_en or on the table.
- R4: A user access (req_priv=0) to either region named in R3 faults with 0x100 for a write and 0x0E0 for a read or fetch. The exception is 0xE0000000..0xE3FFFFFF, which succeeds unchanged. req_kind is encoded as 00 read, 01 write, 10 fetch; 11 behaves as a read.
- R5: With xlate_en=0, every address outside the R3 regions succeeds with paddr = vaddr & 0x1FFFFFFF, whatever the access kind.
- R6: An entry hits when its valid bit is set and the address lies in the page whose base is {vpn,10'b0} with the page-offset bits cleared. wr_sz selects the page size: 00 = 1 KB, 01 = 4 KB, 10 = 64 KB, 11 = 1 MB. On success, paddr is {ppn,10'b0} with the offset bits cleared, OR'd with the offset bits of vaddr.
- R7: The tag comparison is made unless single_vs=1 and req_priv=1. An entry with a tag other than cur_asid cannot hit while the comparison is made, unless its shared bit is set.
- R8: When more than one entry hits, the result is 0x140.
- R9: When no entry hits, the result is 0x060 for a write and 0x040 for a read or fetch.
- R10: A user access to an entry whose wr_prot[1]=0 faults with 0x0C0 for a write and 0x0A0 for a read or fetch.
- R11: A write that passes R10 faults with 0x0C0 if wr_prot[0]=0. Otherwise it faults with 0x080 if the entry's dirty bit is 0.
- R12: A fault returns rsp_ok=0, a nonzero code and paddr 0. Every fault loads tea with vaddr. Every fault except 0x140 loads pteh_vpn with vaddr[31:10]. Both registers hold their values at all other times.
- R13: A successful response has rsp_ok=1 and code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xlate_en | input | 1 | Enables table translation |
| single_vs | input | 1 | Single virtual space: privileged accesses skip the tag check |
| cur_asid | input | 8 | Current address-space tag |
| wr_en | input | 1 | Write one table entry |
| wr_idx | input | log2(N_ENT) | Entry index to write |
| wr_vld | input | 1 | Entry valid |
| wr_shr | input | 1 | Entry shared between all tags |
| wr_asid | input | 8 | Entry tag |
| wr_vpn | input | 22 | Virtual page number (vaddr[31:10]) |
| wr_ppn | input | 19 | Physical page number (paddr[28:10]) |
| wr_sz | input | 2 | Page size code |
| wr_prot | input | 2 | bit1 user allowed, bit0 writable |
| wr_dirty | input | 1 | Page already written |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind |
| req_priv | input | 1 | Privileged access |
| rsp_valid | output | 1 | Result valid |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_code | output | 12 | Exception code, 0 on success |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| tea | output | 32 | Last faulting address |
| pteh_vpn | output | 22 | Page number of last non-multiple-hit fault |

## Verification
The hardest case to reach from the ports is a multiple hit. It requires two valid entries of different sizes that overlap, with the tag rules letting both hit at once. The bench loads a 1 MB page and a 1 KB page inside it, then probes addresses inside the small page, inside only the large page, and just past the large page. It also probes page-edge addresses for every size, and it starts a lookup in the same cycle as a table write to confirm that the lookup is held off.

// File: rtl/vpt_pkg.sv
// Shared types and constants for the variable-page translation checker.
// Assumes a 32-bit virtual space, 1 KB minimum page and 29-bit physical space.
package vpt_pkg;
    localparam int VA_W   = 32;
    localparam int ASID_W = 8;
    localparam int VPN_W  = 22;
    localparam int PPN_W  = 19;
    localparam int CODE_W = 12;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef struct packed {
        logic              vld;
        logic              shr;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [1:0]        sz;
        logic [1:0]        prot;
        logic              dirty;
    } tlb_ent_t;

    localparam logic [CODE_W-1:0] EX_NONE     = 12'h000;
    localparam logic [CODE_W-1:0] EX_MISS_RD  = 12'h040;
    localparam logic [CODE_W-1:0] EX_MISS_WR  = 12'h060;
    localparam logic [CODE_W-1:0] EX_FIRST_WR = 12'h080;
    localparam logic [CODE_W-1:0] EX_PROT_RD  = 12'h0A0;
    localparam logic [CODE_W-1:0] EX_PROT_WR  = 12'h0C0;
    localparam logic [CODE_W-1:0] EX_AERR_RD  = 12'h0E0;
    localparam logic [CODE_W-1:0] EX_AERR_WR  = 12'h100;
    localparam logic [CODE_W-1:0] EX_MULTI    = 12'h140;

    // Ones in the page-offset bits for a size code
    function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
        case (sz)
            2'b00:   page_mask = 32'h0000_03FF;
            2'b01:   page_mask = 32'h0000_0FFF;
            2'b10:   page_mask = 32'h0000_FFFF;
            default: page_mask = 32'h000F_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/vpt_table.sv
// Entry storage: N_ENT registers, one whole entry written per cycle.
// Assumes wr_idx < N_ENT; reset clears every entry (valid bit low).
module vpt_table
    import vpt_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  tlb_ent_t             wr_ent,
    output tlb_ent_t [N_ENT-1:0] ents
);
    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
        // Hold entry gi; load it when addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ents[gi] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
                ents[gi] <= wr_ent;
            end
        end
    end
endmodule

// File: rtl/vpt_match.sv
// Associative search: per-entry hit against the page range, hit count
// reduced to any/multiple, and an AND-OR select of the hitting entry.
// Assumes the selected fields are only meaningful when exactly one hits.
module vpt_match
    import vpt_pkg::*;
#(
    parameter int N_ENT = 8
) (
    input  tlb_ent_t [N_ENT-1:0] ents,
    input  logic [VA_W-1:0]      vaddr,
    input  logic [ASID_W-1:0]    cur_asid,
    input  logic                 chk_asid,
    output logic                 hit_any,
    output logic                 hit_multi,
    output logic [PPN_W-1:0]     sel_ppn,
    output logic [1:0]           sel_sz,
    output logic [1:0]           sel_prot,
    output logic                 sel_dirty
);
    logic [N_ENT-1:0] hit;

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_cmp
        logic [VA_W-1:0] off_m;
        logic            in_page;
        logic            tag_ok;
        // Range test as masked equality of the page-number bits
        always_comb begin
            off_m   = page_mask(ents[gi].sz);
            in_page = ((vaddr & ~off_m) == ({ents[gi].vpn, 10'b0} & ~off_m));
            tag_ok  = !chk_asid || ents[gi].shr || (ents[gi].asid == cur_asid);
            hit[gi] = ents[gi].vld && in_page && tag_ok;
        end
    end

    // Reduce the hit vector and select the hitting entry's fields
    always_comb begin
        hit_any   = 1'b0;
        hit_multi = 1'b0;
        sel_ppn   = '0;
        sel_sz    = '0;
        sel_prot  = '0;
        sel_dirty = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (hit[i]) begin
                if (hit_any) hit_multi = 1'b1;
                hit_any   = 1'b1;
                sel_ppn   = sel_ppn | ents[i].ppn;
                sel_sz    = sel_sz | ents[i].sz;
                sel_prot  = sel_prot | ents[i].prot;
                sel_dirty = sel_dirty | ents[i].dirty;
            end
        end
    end
endmodule

// File: rtl/vpt_judge.sv
// Region decode and fault priority. Purely combinational.
// Order: fixed regions, translation off, multiple hit, miss, user
// protection, write protection, first write, success.
module vpt_judge
    import vpt_pkg::*;
(
    input  logic [VA_W-1:0]   vaddr,
    input  logic [1:0]        kind,
    input  logic              priv,
    input  logic              xlate_en,
    input  logic              hit_any,
    input  logic              hit_multi,
    input  logic [PPN_W-1:0]  sel_ppn,
    input  logic [1:0]        sel_sz,
    input  logic [1:0]        sel_prot,
    input  logic              sel_dirty,
    output logic              ok,
    output logic [CODE_W-1:0] code,
    output logic [VA_W-1:0]   paddr
);
    logic            in_fold;
    logic            in_top;
    logic            in_user_win;
    logic            is_wr;
    logic [VA_W-1:0] off_m;
    logic [VA_W-1:0] pbase;

    // Region flags and page arithmetic
    always_comb begin
        in_fold     = (vaddr[31:30] == 2'b10);
        in_top      = (vaddr[31:29] == 3'b111);
        in_user_win = (vaddr[31:26] == 6'b111000);
        is_wr       = (acc_e'(kind) == ACC_WRITE);
        off_m       = page_mask(sel_sz);
        pbase       = {3'b000, sel_ppn, 10'b0};
    end

    // Prioritised outcome
    always_comb begin
        ok    = 1'b0;
        code  = EX_NONE;
        paddr = '0;
        if (in_fold || in_top) begin
            if (!priv && !in_user_win) begin
                code = is_wr ? EX_AERR_WR : EX_AERR_RD;
            end else begin
                ok    = 1'b1;
                paddr = in_fold ? {3'b000, vaddr[28:0]} : vaddr;
            end
        end else if (!xlate_en) begin
            ok    = 1'b1;
            paddr = {3'b000, vaddr[28:0]};
        end else if (hit_multi) begin
            code = EX_MULTI;
        end else if (!hit_any) begin
            code = is_wr ? EX_MISS_WR : EX_MISS_RD;
        end else if (!priv && !sel_prot[1]) begin
            code = is_wr ? EX_PROT_WR : EX_PROT_RD;
        end else if (is_wr && !sel_prot[0]) begin
            code = EX_PROT_WR;
        end else if (is_wr && !sel_dirty) begin
            code = EX_FIRST_WR;
        end else begin
            ok    = 1'b1;
            paddr = (pbase & ~off_m) | (vaddr & off_m);
        end
    end
endmodule

// File: rtl/vpt_xlate.sv
// Top of the translation checker. Combinational lookup with a registered
// result one cycle after acceptance. Table writes block acceptance so a
// lookup never sees a half-written table. Latches fault context.
module vpt_xlate
    import vpt_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlate_en,
    input  logic              single_vs,
    input  logic [7:0]        cur_asid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_vld,
    input  logic              wr_shr,
    input  logic [7:0]        wr_asid,
    input  logic [21:0]       wr_vpn,
    input  logic [18:0]       wr_ppn,
    input  logic [1:0]        wr_sz,
    input  logic [1:0]        wr_prot,
    input  logic              wr_dirty,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic              req_priv,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [11:0]       rsp_code,
    output logic [31:0]       rsp_paddr,
    output logic [31:0]       tea,
    output logic [21:0]       pteh_vpn
);
    tlb_ent_t [N_ENT-1:0] ents;
    tlb_ent_t             wr_ent;
    logic                 chk_asid;
    logic                 accept;
    logic                 hit_any;
    logic                 hit_multi;
    logic [PPN_W-1:0]     sel_ppn;
    logic [1:0]           sel_sz;
    logic [1:0]           sel_prot;
    logic                 sel_dirty;
    logic                 nx_ok;
    logic [CODE_W-1:0]    nx_code;
    logic [VA_W-1:0]      nx_paddr;

    // Pack the write-port fields and derive the handshake and tag rule
    always_comb begin
        wr_ent    = '{vld: wr_vld, shr: wr_shr, asid: wr_asid, vpn: wr_vpn,
                      ppn: wr_ppn, sz: wr_sz, prot: wr_prot, dirty: wr_dirty};
        req_ready = !wr_en;
        accept    = req_valid && req_ready;
        chk_asid  = !(single_vs && req_priv);
    end

    vpt_table #(.N_ENT(N_ENT)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_ent (wr_ent),
        .ents   (ents)
    );

    vpt_match #(.N_ENT(N_ENT)) u_match (
        .ents      (ents),
        .vaddr     (req_vaddr),
        .cur_asid  (cur_asid),
        .chk_asid  (chk_asid),
        .hit_any   (hit_any),
        .hit_multi (hit_multi),
        .sel_ppn   (sel_ppn),
        .sel_sz    (sel_sz),
        .sel_prot  (sel_prot),
        .sel_dirty (sel_dirty)
    );

    vpt_judge u_judge (
        .vaddr     (req_vaddr),
        .kind      (req_kind),
        .priv      (req_priv),
        .xlate_en  (xlate_en),
        .hit_any   (hit_any),
        .hit_multi (hit_multi),
        .sel_ppn   (sel_ppn),
        .sel_sz    (sel_sz),
        .sel_prot  (sel_prot),
        .sel_dirty (sel_dirty),
        .ok        (nx_ok),
        .code      (nx_code),
        .paddr     (nx_paddr)
    );

    // Register the result and the fault context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_code  <= '0;
            rsp_paddr <= '0;
            tea       <= '0;
            pteh_vpn  <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_ok    <= nx_ok;
                rsp_code  <= nx_code;
                rsp_paddr <= nx_paddr;
                if (!nx_ok) begin
                    tea <= req_vaddr;
                    if (nx_code != EX_MULTI) pteh_vpn <= req_vaddr[31:10];
                end
            end
        end
    end
endmodule

// File: rtl/vpt_xlate_chk.sv
// Property checker for vpt_xlate, attached with bind below.
module vpt_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic        req_priv,
    input logic        rsp_valid,
    input logic        rsp_ok,
    input logic [11:0] rsp_code,
    input logic [31:0] rsp_paddr,
    input logic [31:0] tea
);
    AST_WRITE_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !req_ready); // R2
    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid); // R2
    AST_FOLD_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_priv && req_vaddr[31:30] == 2'b10)
        |=> (rsp_ok && rsp_paddr == {3'b000, $past(req_vaddr[28:0])})); // R3
    AST_USER_AREA_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_priv && req_vaddr[31:30] == 2'b10)
        |=> (!rsp_ok && (rsp_code == 12'h0E0 || rsp_code == 12'h100))); // R4
    AST_FAULT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> (rsp_code != 12'h000 && rsp_paddr == 32'h0)); // R12
    AST_TEA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_ok || tea == $past(req_vaddr))); // R12
    AST_TEA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && !rsp_ok) |-> $stable(tea)); // R12
    AST_OK_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok) |-> rsp_code == 12'h000); // R13
endmodule

bind vpt_xlate vpt_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .req_priv  (req_priv),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .rsp_code  (rsp_code),
    .rsp_paddr (rsp_paddr),
    .tea       (tea)
);

// File: tb/vpt_xlate_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference table and range search, compared every clock.
module vpt_xlate_tb;
    localparam int N_ENT = 8;
    localparam int MAX_CYC = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_en = 1'b0, single_vs = 1'b0;
    logic [7:0]  cur_asid = 8'h0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic        wr_vld = 1'b0, wr_shr = 1'b0, wr_dirty = 1'b0;
    logic [7:0]  wr_asid = '0;
    logic [21:0] wr_vpn = '0;
    logic [18:0] wr_ppn = '0;
    logic [1:0]  wr_sz = '0, wr_prot = '0;
    logic        req_valid = 1'b0, req_priv = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_ready, rsp_valid, rsp_ok;
    logic [11:0] rsp_code;
    logic [31:0] rsp_paddr, tea;
    logic [21:0] pteh_vpn;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;
    string drv_tag = "R1", exp_tag = "R1";

    always #2.5 clk = ~clk;

    vpt_xlate #(.N_ENT(N_ENT)) u_dut (
        .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .single_vs(single_vs),
        .cur_asid(cur_asid), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vld(wr_vld),
        .wr_shr(wr_shr), .wr_asid(wr_asid), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
        .wr_sz(wr_sz), .wr_prot(wr_prot), .wr_dirty(wr_dirty),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_priv(req_priv), .rsp_valid(rsp_valid),
        .rsp_ok(rsp_ok), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr),
        .tea(tea), .pteh_vpn(pteh_vpn)
    );

    // Reference table
    bit          m_v[N_ENT], m_sh[N_ENT], m_d[N_ENT];
    int unsigned m_asid[N_ENT], m_vpn[N_ENT], m_ppn[N_ENT], m_sz[N_ENT], m_pr[N_ENT];
    bit          exp_valid = 0, exp_ok = 0;
    logic [11:0] exp_code = 0;
    logic [31:0] exp_pa = 0, exp_tea = 0;
    logic [21:0] exp_pteh = 0;

    function automatic void ref_lookup(input logic [31:0] a, input logic [1:0] k,
                                       input bit pv, output bit ok,
                                       output logic [11:0] code, output logic [31:0] pa);
        bit wr = (k == 2'b01);
        longint unsigned av = a;
        int hits = 0, hi = 0;
        ok = 0; code = 0; pa = 0;
        if ((av >= 64'h8000_0000 && av < 64'hC000_0000) || av >= 64'hE000_0000) begin
            if (!pv && !(av >= 64'hE000_0000 && av < 64'hE400_0000))
                code = wr ? 12'h100 : 12'h0E0;
            else begin
                ok = 1;
                pa = (av < 64'hC000_0000) ? (a & 32'h1FFF_FFFF) : a;
            end
            return;
        end
        if (!xlate_en) begin ok = 1; pa = a & 32'h1FFF_FFFF; return; end
        for (int i = 0; i < N_ENT; i++) begin
            longint unsigned sz, st, en;
            sz = 64'd1024 << ((m_sz[i] == 0) ? 0 : (m_sz[i] == 1) ? 2 : (m_sz[i] == 2) ? 6 : 10);
            st = (longint'(m_vpn[i]) * 1024) & ~(sz - 1);
            en = st + sz - 1;
            if (m_v[i] && (m_sh[i] || (single_vs && pv) || m_asid[i] == cur_asid)
                && av >= st && av <= en) begin
                hits++; hi = i;
            end
        end
        if (hits > 1) code = 12'h140;
        else if (hits == 0) code = wr ? 12'h060 : 12'h040;
        else if (!pv && !m_pr[hi][1]) code = wr ? 12'h0C0 : 12'h0A0;
        else if (wr && !m_pr[hi][0]) code = 12'h0C0;
        else if (wr && !m_d[hi]) code = 12'h080;
        else begin
            longint unsigned sz;
            sz = 64'd1024 << ((m_sz[hi] == 0) ? 0 : (m_sz[hi] == 1) ? 2 : (m_sz[hi] == 2) ? 6 : 10);
            ok = 1;
            pa = 32'(((longint'(m_ppn[hi]) * 1024) & ~(sz - 1)) | (av & (sz - 1)));
        end
    endfunction

    // Reference model advances on each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) m_v[i] = 0;
            exp_valid = 0; exp_tea = 0; exp_pteh = 0;
        end else begin
            exp_valid = req_valid && !wr_en;
            if (exp_valid) begin
                ref_lookup(req_vaddr, req_kind, req_priv, exp_ok, exp_code, exp_pa);
                exp_tag = drv_tag;
                if (!exp_ok) begin
                    exp_tea = req_vaddr;
                    if (exp_code != 12'h140) exp_pteh = req_vaddr[31:10];
                end
            end
            if (wr_en) begin
                m_v[wr_idx] = wr_vld; m_sh[wr_idx] = wr_shr; m_asid[wr_idx] = wr_asid;
                m_vpn[wr_idx] = wr_vpn; m_ppn[wr_idx] = wr_ppn; m_sz[wr_idx] = wr_sz;
                m_pr[wr_idx] = wr_prot; m_d[wr_idx] = wr_dirty;
            end
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare against the model away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                check("R1", "rsp_valid in reset", 32'(rsp_valid), 0);
                check("R1", "tea in reset", tea, 0);
                check("R1", "pteh in reset", 32'(pteh_vpn), 0);
            end else begin
                check("R2", "rsp_valid", 32'(rsp_valid), 32'(exp_valid));
                if (exp_valid) begin
                    check(exp_ok ? "R13" : exp_tag, "rsp_ok", 32'(rsp_ok), 32'(exp_ok));
                    check(exp_tag, "rsp_code", 32'(rsp_code), 32'(exp_code));
                    check(exp_tag, "rsp_paddr", rsp_paddr, exp_pa);
                end
                check("R12", "tea", tea, exp_tea);
                check("R12", "pteh_vpn", 32'(pteh_vpn), 32'(exp_pteh));
            end
        end
    end

    task automatic lookup(input string tag, input logic [31:0] a,
                          input logic [1:0] k, input bit pv);
        @(posedge clk); #1;
        drv_tag = tag; req_valid = 1; req_vaddr = a; req_kind = k; req_priv = pv;
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic load(input int idx, input bit v, input bit sh, input int asid,
                        input int vpn, input int ppn, input int sz, input int pr,
                        input bit d, input bit with_req);
        @(posedge clk); #1;
        wr_en = 1; wr_idx = 3'(idx); wr_vld = v; wr_shr = sh; wr_asid = 8'(asid);
        wr_vpn = 22'(vpn); wr_ppn = 19'(ppn); wr_sz = 2'(sz); wr_prot = 2'(pr);
        wr_dirty = d;
        if (with_req) begin
            drv_tag = "R2"; req_valid = 1; req_vaddr = 32'h8000_0100; req_priv = 1;
        end
        @(posedge clk); #1;
        wr_en = 0; req_valid = 0;
    endtask

    task automatic cfg(input bit xe, input bit sv, input int asid);
        @(posedge clk); #1;
        xlate_en = xe; single_vs = sv; cur_asid = 8'(asid);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        // R5: translation off
        lookup("R5", 32'h1234_5678, 2'b00, 0);
        lookup("R5", 32'hC000_1000, 2'b01, 0);
        lookup("R5", 32'h7FFF_FFFC, 2'b10, 1);
        // R3: fixed regions, privileged
        lookup("R3", 32'h8123_4567, 2'b00, 1);
        lookup("R3", 32'hA000_0010, 2'b01, 1);
        lookup("R3", 32'hFF00_0000, 2'b10, 1);
        // R4: user in fixed regions
        lookup("R4", 32'h8000_0000, 2'b00, 0);
        lookup("R4", 32'hBFFF_FFFF, 2'b01, 0);
        lookup("R4", 32'hA000_0000, 2'b10, 0);
        lookup("R4", 32'hE000_0040, 2'b01, 0);
        lookup("R4", 32'hE3FF_FFFC, 2'b00, 0);
        lookup("R4", 32'hE400_0000, 2'b01, 0);
        lookup("R4", 32'hFFFF_FFFF, 2'b11, 0);
        // R1 / R9: empty table
        cfg(1, 0, 5);
        lookup("R1", 32'h0000_1000, 2'b00, 1);
        lookup("R9", 32'h0000_1000, 2'b01, 1);
        lookup("R9", 32'hC000_0000, 2'b10, 0);
        // Load entries
        load(0, 1, 0, 5, 22'h001000, 19'h00100, 0, 3, 1, 0);
        load(1, 1, 0, 5, 22'h004003, 19'h02001, 1, 3, 1, 0);
        load(2, 1, 1, 9, 22'h080000, 19'h10000, 2, 2, 1, 0);
        load(3, 1, 0, 5, 22'h0C0000, 19'h40000, 3, 1, 0, 0);
        load(4, 1, 0, 5, 22'h0C0001, 19'h00200, 0, 3, 1, 1); // R2: request held off
        load(5, 1, 0, 7, 22'h300000, 19'h00300, 0, 3, 1, 0);
        // R6: page sizes, alignment and edges
        lookup("R6", 32'h0040_0123, 2'b00, 0);
        lookup("R6", 32'h0040_03FF, 2'b01, 0);
        lookup("R6", 32'h0040_0400, 2'b00, 0);
        lookup("R6", 32'h0100_0ABC, 2'b10, 0);
        lookup("R6", 32'h0100_1000, 2'b00, 0);
        lookup("R6", 32'h2000_FFFF, 2'b00, 0);
        lookup("R6", 32'h2001_0000, 2'b00, 0);
        lookup("R6", 32'h300F_FFFC, 2'b00, 1);
        lookup("R6", 32'h3010_0000, 2'b00, 1);
        // R8: overlapping 1 MB and 1 KB pages
        lookup("R8", 32'h3000_0500, 2'b00, 1);
        lookup("R8", 32'h3000_07FC, 2'b01, 1);
        // R10 / R11: protection ordering
        lookup("R10", 32'h3000_0000, 2'b00, 0);
        lookup("R10", 32'h3000_0010, 2'b01, 0);
        lookup("R11", 32'h3000_0020, 2'b01, 1);
        lookup("R11", 32'h2000_0040, 2'b01, 1);
        lookup("R11", 32'h2000_0040, 2'b01, 0);
        lookup("R10", 32'h2000_0080, 2'b10, 0);
        // R7: tag rules
        cfg(1, 0, 6);
        lookup("R7", 32'h0040_0123, 2'b00, 1);
        lookup("R7", 32'h2000_1234, 2'b00, 0);
        cfg(1, 1, 6);
        lookup("R7", 32'h0040_0123, 2'b00, 1);
        lookup("R7", 32'h0040_0123, 2'b00, 0);
        lookup("R7", 32'hC000_0200, 2'b10, 1);
        cfg(1, 0, 7);
        lookup("R7", 32'hC000_0200, 2'b10, 0);
        // R8 undone: invalidate the small page
        cfg(1, 0, 5);
        load(4, 0, 0, 5, 22'h0C0001, 19'h00200, 0, 3, 1, 0);
        lookup("R8", 32'h3000_0500, 2'b00, 1);
        // R5 again with a loaded table
        cfg(0, 0, 5);
        lookup("R5", 32'h0040_0123, 2'b01, 0);
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(MAX_CYC * 5.0);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule